// File: doc/BRIEF.md
# Wishbone Field Register Bank

This block is a Wishbone slave that holds control and monitor fields for logic that has no bus of its own. Each field is one of three kinds. A setting field stores a value written by the bus and drives it out as a configuration vector. A status field returns an input vector on a read, and bus writes do not change it. A trigger field is a single bit. A bus write of 1 sets it to start an outside process, and that process clears it with a pulse on its clear input once it has accepted the request.

The word address, lowest bit position and width of every field are elaboration-time parameters. Fields of different kinds may share one word, each in its own bits. The bus side is a classic single-access slave with a registered acknowledge.

With the default parameters (4-bit address, 16-bit data) the layout is as follows. Word 0 holds setting field 0 in bits 7:0 (reset 0xA5), status field 0 in bits 11:8 and trigger 0 in bit 12. Word 1 holds trigger 1 in bit 0 and setting field 1 in bits 9:4 (reset 0x15). Word 2 holds status field 1 in bits 11:0 and trigger 2 in bit 15. Word 3 and every other word contain no fields.

Top module: `cfg_field_bank`

## Requirements
- R1: A cycle with `wb_cyc_i` and `wb_stb_i` high while `wb_ack_o` is low is answered by `wb_ack_o` high in the next cycle for exactly one cycle. Otherwise `wb_ack_o` stays low.
- R2: A write loads each setting field at the addressed word from its bit positions of `wb_dat_i`. The new value is on `set_out[i]`, zero-extended, in the cycle that carries the acknowledge. Other data bits do not touch the field.
- R3: A read returns each setting field at the addressed word in its bit positions of `wb_dat_o`, in the acknowledge cycle.
- R4: A read returns the low bits of `sts_in[i]`, taken at the request edge, in the positions of each status field at that word. A write to status bits has no effect on them.
- R5: A write with bit 1 at a trigger's position sets `trg_out[i]`. A write with bit 0 there leaves it unchanged. A read returns the trigger's state.
- R6: When `trg_clr[i]` is high and no write sets that trigger in the same cycle, `trg_out[i]` is 0 in the next cycle.
- R7: A bus write of 1 to a trigger and `trg_clr` for that same trigger in one cycle leave the trigger set.
- R8: Bits of a word that belong to no field read as 0, and a word with no fields reads as 0.
- R9: A low `rst_n` at a clock edge loads each setting field with its default value (0xA5 and 0x15), clears every trigger and clears `wb_ack_o`.
- R10: One write to a shared word updates the setting field and the trigger at that word together, and it leaves the status bits there unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Word address |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, registered |
| wb_ack_o | output | 1 | Acknowledge, one cycle |
| set_out | output | N_SET x DATA_W | Setting field values, zero-extended |
| sts_in | input | N_STS x DATA_W | Status inputs; only the field's low bits are used |
| trg_out | output | N_TRG | Trigger bits |
| trg_clr | input | N_TRG | Clear pulse from the started process |

## Verification
A bus write that sets a trigger and the clear pulse from the outside process can reach the same trigger bit on the same clock edge. The bench first clears trigger 0. It then raises `trg_clr[0]` in the same cycle as a write of 0x1000 to word 0 and expects the trigger still set afterwards. A clear pulse on its own then has to drop the bit. That check also catches a design that lets the clear win.

// File: rtl/cfg_bank_pkg.sv
// Package: shared helpers for the field register bank.
// Assumes field widths never exceed 64 bits.
package cfg_bank_pkg;

    // Returns a vector with the low w bits set.
    function automatic logic [63:0] low_mask(input int unsigned w);
        logic [63:0] m;
        m = '0;
        for (int unsigned k = 0; k < 64; k++) begin
            if (k < w) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_bus_port.sv
// Bus port: single-access Wishbone slave handshake.
// Raises a registered acknowledge one cycle after a request, captures
// the read word at the request edge and issues a write strobe during
// the request cycle. Assumes the master drops its strobe after the ack.
module cfg_bus_port #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_en,
    output logic              ack_o,
    output logic [DATA_W-1:0] dat_o
);

    logic req;

    // New request: strobe present and not already acknowledged.
    assign req   = cyc_i && stb_i && !ack_o;
    assign wr_en = req && we_i;

    // Acknowledge and read-data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            dat_o <= '0;
        end else begin
            ack_o <= req;
            if (req) dat_o <= rd_word;
        end
    end

    a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r1_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cyc_i && stb_i));

endmodule

// File: rtl/cfg_set_field.sv
// Setting field: a register of WIDTH bits loaded from its slice of the
// write data when its word is written. Reset loads RST.
module cfg_set_field #(
    parameter int unsigned       WIDTH = 8,
    parameter logic [WIDTH-1:0]  RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] value
);

    // Field storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= RST;
        else if (wr_hit) value <= wr_data;
    end

    a_r2_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(value));

    a_r2_loads_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> value == $past(wr_data));

endmodule

// File: rtl/cfg_trig_bit.sv
// Trigger bit: set by a bus write of 1 and cleared by the external
// clear pulse. A set in the same cycle as a clear wins.
module cfg_trig_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    // Trigger state with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);

    a_r5_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q));

endmodule

// File: rtl/cfg_field_bank.sv
// Field register bank: Wishbone slave holding setting, status and
// trigger fields whose word address, lowest bit and width are parameters.
// Assumes fields at one word do not overlap and every field fits DATA_W.
module cfg_field_bank
    import cfg_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_SET  = 2,
    parameter int unsigned N_STS  = 2,
    parameter int unsigned N_TRG  = 3,
    parameter int unsigned SET_ADDR [N_SET] = '{0, 1},
    parameter int unsigned SET_LSB  [N_SET] = '{0, 4},
    parameter int unsigned SET_W    [N_SET] = '{8, 6},
    parameter logic [DATA_W-1:0] SET_RST [N_SET] = '{16'h00A5, 16'h0015},
    parameter int unsigned STS_ADDR [N_STS] = '{0, 2},
    parameter int unsigned STS_LSB  [N_STS] = '{8, 0},
    parameter int unsigned STS_W    [N_STS] = '{4, 12},
    parameter int unsigned TRG_ADDR [N_TRG] = '{0, 1, 2},
    parameter int unsigned TRG_BIT  [N_TRG] = '{12, 0, 15}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wb_cyc_i,
    input  logic                         wb_stb_i,
    input  logic                         wb_we_i,
    input  logic [ADDR_W-1:0]            wb_adr_i,
    input  logic [DATA_W-1:0]            wb_dat_i,
    output logic [DATA_W-1:0]            wb_dat_o,
    output logic                         wb_ack_o,
    output logic [N_SET-1:0][DATA_W-1:0] set_out,
    input  logic [N_STS-1:0][DATA_W-1:0] sts_in,
    output logic [N_TRG-1:0]             trg_out,
    input  logic [N_TRG-1:0]             trg_clr
);

    logic              wr_en;
    logic [DATA_W-1:0] rd_word;
    logic [N_SET-1:0]  set_sel;
    logic [N_STS-1:0]  sts_sel;
    logic [N_TRG-1:0]  trg_sel;
    logic [DATA_W-1:0] set_rd [N_SET];
    logic [DATA_W-1:0] sts_rd [N_STS];
    logic [DATA_W-1:0] trg_rd [N_TRG];
    logic              in_unused;

    // Data bits outside every field and status bits above a field's width.
    assign in_unused = ^{wb_dat_i, sts_in};

    cfg_bus_port #(.DATA_W(DATA_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_i   (wb_cyc_i),
        .stb_i   (wb_stb_i),
        .we_i    (wb_we_i),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .ack_o   (wb_ack_o),
        .dat_o   (wb_dat_o)
    );

    // Setting fields.
    for (genvar g = 0; g < N_SET; g++) begin : g_set
        localparam int unsigned W = SET_W[g];
        localparam int unsigned L = SET_LSB[g];
        logic [W-1:0] val;
        assign set_sel[g] = (wb_adr_i == ADDR_W'(SET_ADDR[g]));
        cfg_set_field #(.WIDTH(W), .RST(SET_RST[g][W-1:0])) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_en && set_sel[g]),
            .wr_data (wb_dat_i[L +: W]),
            .value   (val)
        );
        assign set_out[g] = DATA_W'(val);
        assign set_rd[g]  = DATA_W'(val) << L;
    end

    // Status fields: read-only views of the inputs.
    for (genvar g = 0; g < N_STS; g++) begin : g_sts
        localparam int unsigned W = STS_W[g];
        localparam int unsigned L = STS_LSB[g];
        assign sts_sel[g] = (wb_adr_i == ADDR_W'(STS_ADDR[g]));
        assign sts_rd[g]  = DATA_W'(sts_in[g][W-1:0]) << L;
    end

    // Trigger bits.
    for (genvar g = 0; g < N_TRG; g++) begin : g_trg
        localparam int unsigned B = TRG_BIT[g];
        assign trg_sel[g] = (wb_adr_i == ADDR_W'(TRG_ADDR[g]));
        cfg_trig_bit u_trg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (wr_en && trg_sel[g] && wb_dat_i[B]),
            .clr_i (trg_clr[g]),
            .q     (trg_out[g])
        );
        assign trg_rd[g] = DATA_W'(trg_out[g]) << B;
    end

    // Read multiplexer: OR of every field placed at the addressed word.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < int'(N_SET); i++) if (set_sel[i]) rd_word = rd_word | set_rd[i];
        for (int i = 0; i < int'(N_STS); i++) if (sts_sel[i]) rd_word = rd_word | sts_rd[i];
        for (int i = 0; i < int'(N_TRG); i++) if (trg_sel[i]) rd_word = rd_word | trg_rd[i];
    end

    // R8: a status field never shows bits above its width.
    for (genvar g = 0; g < N_STS; g++) begin : g_chk
        a_r8_status_width: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_rd[g] & ~(DATA_W'(low_mask(STS_W[g])) << STS_LSB[g])) == '0);
    end

endmodule

// File: tb/cfg_field_bank_tb.sv
`timescale 1ns/1ps
module cfg_field_bank_tb_top;

    typedef struct {
        bit          is_rd;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
    logic [3:0]       wb_adr_i = '0;
    logic [15:0]      wb_dat_i = '0;
    logic [15:0]      wb_dat_o;
    logic             wb_ack_o;
    logic [1:0][15:0] set_out;
    logic [1:0][15:0] sts_in;
    logic [2:0]       trg_out;
    logic [2:0]       trg_clr = '0;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    sb_item_t sb[$];

    always #4 clk = ~clk;

    cfg_field_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
        .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
        .set_out(set_out), .sts_in(sts_in),
        .trg_out(trg_out), .trg_clr(trg_clr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one bus access, optional clear pulse in the same cycle.
    task automatic wb_cycle(input bit we, input logic [3:0] a, input logic [15:0] d,
                            input logic [15:0] exp, input logic [2:0] clr, input string tag);
        sb_item_t it;
        @(negedge clk);
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = we; wb_adr_i = a; wb_dat_i = d;
        trg_clr = clr;
        it.is_rd = !we; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0; trg_clr = '0;
    endtask

    task automatic clr_pulse(input logic [2:0] clr);
        @(negedge clk);
        trg_clr = clr;
        @(negedge clk);
        trg_clr = '0;
    endtask

    // Monitor: compares each acknowledged read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && wb_ack_o) begin
            if (sb.size() == 0) begin
                vectors++; misses++;
                $display("FAIL R1: got unexpected ack expected none");
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if (it.is_rd) chk(it.tag, wb_dat_o, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        sts_in[0] = 16'hFFF7;
        sts_in[1] = 16'hF123;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 set0 default", set_out[0], 16'h00A5);
        chk("R9 set1 default", set_out[1], 16'h0015);
        chk("R9 triggers clear", {13'd0, trg_out}, 16'h0000);
        chk("R9 ack low", {15'd0, wb_ack_o}, 16'h0000);
        rst_n = 1;

        // R3 R4 R8: word 0 read after reset
        wb_cycle(0, 4'd0, 16'h0, 16'h07A5, 3'b000, "R3 R4 word0 read");
        chk("R1 ack held one cycle", {15'd0, wb_ack_o}, 16'h0001);
        @(negedge clk);
        chk("R1 ack drops", {15'd0, wb_ack_o}, 16'h0000);

        // R10 R2 R5: write all ones to shared word 0
        wb_cycle(1, 4'd0, 16'hFFFF, 16'h0, 3'b000, "R10 write");
        chk("R2 set0 written", set_out[0], 16'h00FF);
        chk("R10 trg0 set with set0", {13'd0, trg_out}, 16'h0001);
        wb_cycle(0, 4'd0, 16'h0, 16'h17FF, 3'b000, "R4 R10 word0 readback");

        // R2 R5: word 1
        wb_cycle(1, 4'd1, 16'h0000, 16'h0, 3'b000, "R5 write zero");
        chk("R5 zero leaves trg1", {13'd0, trg_out}, 16'h0001);
        chk("R2 set1 zero", set_out[1], 16'h0000);
        wb_cycle(1, 4'd1, 16'hFFFF, 16'h0, 3'b000, "R2 write");
        chk("R2 set1 masked", set_out[1], 16'h003F);
        wb_cycle(0, 4'd1, 16'h0, 16'h03F1, 3'b000, "R3 R8 word1 read");
        wb_cycle(1, 4'd1, 16'h0000, 16'h0, 3'b000, "R5 write zero");
        wb_cycle(0, 4'd1, 16'h0, 16'h0001, 3'b000, "R5 trg1 kept");

        // R6: clear pulses
        clr_pulse(3'b010);
        chk("R6 trg1 cleared", {13'd0, trg_out}, 16'h0001);
        clr_pulse(3'b001);
        chk("R6 trg0 cleared", {13'd0, trg_out}, 16'h0000);

        // R7: set and clear in the same cycle
        wb_cycle(1, 4'd0, 16'h1000, 16'h0, 3'b001, "R7 write");
        chk("R7 set wins", {13'd0, trg_out}, 16'h0001);
        chk("R2 set0 rewritten", set_out[0], 16'h0000);
        clr_pulse(3'b001);
        chk("R6 clear after collision", {13'd0, trg_out}, 16'h0000);

        // R4 R8: word 2 and empty word 3
        wb_cycle(0, 4'd2, 16'h0, 16'h0123, 3'b000, "R4 word2 read");
        wb_cycle(0, 4'd3, 16'h0, 16'h0000, 3'b000, "R8 empty word");
        wb_cycle(1, 4'd2, 16'hFFFF, 16'h0, 3'b000, "R4 write status");
        wb_cycle(0, 4'd2, 16'h0, 16'h8123, 3'b000, "R4 status unchanged R5 trg2");
        sts_in[1] = 16'h0ABC;
        wb_cycle(0, 4'd2, 16'h0, 16'h8ABC, 3'b000, "R4 new status");

        repeat (2) @(negedge clk);
        chk("R1 all acks seen", 16'(sb.size()), 16'h0000);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule